// File: doc/BRIEF.md
# Serial Identity Responder

This block answers an identification request with a fixed serial identity word. It sits idle until the request line is seen high. It then places the identity word on a one-bit output, one bit per clock cycle, most significant bit first. After the last bit it goes back to idle.

The request comes from a source that is not tied to the block's clock. For that reason it first passes through a chain of synchronizer registers, which is one register deep by default, before the sequencing logic sees it. The sequencer holds a binary state number. Zero is the idle state, and state k sends identity bit k, counted from the most significant end. Any state number above the last bit state leads back to idle on the next edge. The identity word, its width and the depth of the synchronizer are parameters. The default word is 4'b1101, so the output sends 1, 1, 0, 1.

Top module: `id_serial_responder`

## Requirements
- R1: A synchronous active-high reset puts the block in idle with the output at 0 and clears the synchronizer. A request that is high in the cycle reset is applied does not start a transmission after reset is released.
- R2: While the synchronized request is low in idle, the output stays 0.
- R3: A request driven high before rising edge E is captured by the one-register synchronizer at E. The sequencer leaves idle at E+1, so the first identity bit is on the output after edge E+1.
- R4: The identity word is sent most significant bit first, one bit per cycle. With the default word 4'b1101 the output is 1, 1, 0, 1 on four consecutive cycles.
- R5: After the last identity bit the block returns to idle for at least one cycle, with the output at 0.
- R6: A request that arrives while a transmission is in progress is ignored. It neither restarts nor extends that transmission.
- R7: A request held continuously high repeats the identity word with one idle cycle between copies, a period of ID_BITS+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_async | input | 1 | Identification request, asynchronous to clk |
| id_serial | output | 1 | Registered serial identity output |

## Verification
Take a request driven just after a falling edge. The output still shows idle one full cycle later, because the synchronizer has only just captured the request. The first identity bit is due two cycles after the request, and the bits follow at offsets 3 to 5, with idle again at offset 6. The driver therefore queues one expected output value for every cycle it drives. The monitor samples the output once per cycle, one nanosecond after each falling edge, and pops the expected value that belongs to that cycle. Requests during a transmission, a held request, back-to-back requests and a reset in mid-word are placed at chosen offsets, so each check lands on the exact cycle its requirement fixes.

// File: rtl/id_serial_pkg.sv
package id_serial_pkg;
  // Number of bits needed to hold state numbers 0 .. n-1.
  function automatic int unsigned num_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/idsr_sync.sv
module idsr_sync #(
  parameter int unsigned STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];

  // R1: a cleared chain reads 0 on the cycle after reset
  p_sync_clear_r1: assert property (@(posedge clk) rst |=> (q_sync == 1'b0));
endmodule

// File: rtl/idsr_seq.sv
module idsr_seq #(
  parameter int unsigned ID_BITS = 4,
  parameter int unsigned SW      = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_sync,
  output logic [SW-1:0] state_q,
  output logic [SW-1:0] state_nx
);
  localparam logic [SW-1:0] ST_IDLE  = '0;
  localparam logic [SW-1:0] ST_FIRST = SW'(1);
  localparam logic [SW-1:0] ST_LAST  = SW'(ID_BITS);

  always_comb begin
    state_nx = ST_IDLE;
    if (state_q == ST_IDLE) begin
      state_nx = req_sync ? ST_FIRST : ST_IDLE;
    end else if (state_q < ST_LAST) begin
      state_nx = state_q + SW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_nx;
  end

  // R2: idle holds while no request is seen
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !req_sync) |=> (state_q == ST_IDLE));
  // R3: a seen request starts the word on the next edge
  p_start_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && req_sync) |=> (state_q == ST_FIRST));
  // R4, R6: mid-word states advance by one regardless of the request
  p_advance_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && state_q < ST_LAST) |=> (state_q == $past(state_q) + SW'(1)));
  // R5: the last bit state is followed by idle
  p_return_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LAST) |=> (state_q == ST_IDLE));
  // R4: no state number beyond the last bit is ever held
  p_legal_r4: assert property (@(posedge clk) disable iff (rst)
    state_q <= ST_LAST);
endmodule

// File: rtl/idsr_out.sv
module idsr_out #(
  parameter int unsigned       ID_BITS    = 4,
  parameter logic [ID_BITS-1:0] ID_PATTERN = 4'b1101,
  parameter int unsigned       SW         = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] state_nx,
  output logic          bit_q
);
  logic bit_d;

  // State k (1..ID_BITS) sends pattern bit ID_BITS-k, most significant first.
  always_comb begin
    bit_d = 1'b0;
    for (int k = 1; k <= int'(ID_BITS); k++) begin
      if (state_nx == SW'(k)) bit_d = ID_PATTERN[int'(ID_BITS) - k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bit_q <= 1'b0;
    else     bit_q <= bit_d;
  end
endmodule

// File: rtl/id_serial_responder.sv
module id_serial_responder #(
  parameter int unsigned        ID_BITS     = 4,
  parameter logic [ID_BITS-1:0] ID_PATTERN  = 4'b1101,
  parameter int unsigned        SYNC_STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic req_async,
  output logic id_serial
);
  import id_serial_pkg::*;

  localparam int unsigned SW = num_bits(ID_BITS + 1);

  logic          req_sync;
  logic [SW-1:0] state_q;
  logic [SW-1:0] state_nx;

  idsr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (req_async),
    .q_sync  (req_sync)
  );

  idsr_seq #(.ID_BITS(ID_BITS), .SW(SW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req_sync (req_sync),
    .state_q  (state_q),
    .state_nx (state_nx)
  );

  idsr_out #(.ID_BITS(ID_BITS), .ID_PATTERN(ID_PATTERN), .SW(SW)) u_out (
    .clk      (clk),
    .rst      (rst),
    .state_nx (state_nx),
    .bit_q    (id_serial)
  );

  // R1: reset drives the output low on the following cycle
  p_reset_out_r1: assert property (@(posedge clk) rst |=> (id_serial == 1'b0));
  // R5: output is low whenever the sequencer is idle
  p_idle_low_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == '0) |-> (id_serial == 1'b0));
endmodule

// File: tb/test_id_serial_responder.sv
module test_id_serial_responder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_async = 1'b0;
  logic id_serial;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    logic  val;
    string tag;
    int    cyc;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  id_serial_responder i_id_serial_responder (
    .clk       (clk),
    .rst       (rst),
    .req_async (req_async),
    .id_serial (id_serial)
  );

  // Driver: bit i of each vector applies to cycle i of the case.
  task automatic run_case(input string tag, input int len,
                          input logic [31:0] req_v, input logic [31:0] rst_v,
                          input logic [31:0] exp_v);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rst       = rst_v[i];
      req_async = req_v[i];
      exp_q.push_back('{val: exp_v[i], tag: tag, cyc: i});
    end
  endtask

  // Monitor: compare one expected item per cycle, 1 ns after the falling edge.
  always @(negedge clk) begin
    #1;
    cyc++;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_checks++;
      if (id_serial !== e.val) begin
        n_fail++;
        $display("FAIL %s case cycle %0d: id_serial=%0b expected %0b",
                 e.tag, e.cyc, id_serial, e.val);
      end
    end
  end

  initial begin
    // R1: reset state, output low while and after reset
    run_case("R1", 6, 32'h0, 32'h7, 32'h0);
    // R2: no request, output stays low
    run_case("R2", 8, 32'h0, 32'h0, 32'h0);
    // R3/R4/R5: single pulse at cycle 1, bits 1101 at cycles 3..6, idle at 7
    run_case("R3/R4/R5", 10, 32'h2, 32'h0, 32'h58);
    // R7: request held for 12 cycles, word repeats every 5 cycles
    run_case("R7", 18, 32'hFFF, 32'h0, 32'hB5AC);
    // R6: extra pulses at cycles 3 and 5 fall inside the word and are ignored
    run_case("R6", 11, 32'h2A, 32'h0, 32'h58);
    // R5: second pulse at cycle 6 is seen in the idle gap and starts a new word
    run_case("R5", 14, 32'h42, 32'h0, 32'hB58);
    // R1: reset in mid-word with a request high at the same cycle
    run_case("R1", 9, 32'h12, 32'h10, 32'h18);
    @(negedge clk);
    req_async = 1'b0;
    rst = 1'b0;
    wait (exp_q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule